// File: doc/BRIEF.md
# Twin-Predicated Element Index Sequencer

This block generates the element index pairs for a vector move that is predicated twice, once on the source and once on the destination. The source mask compacts the source: cleared positions are passed over. The destination mask spreads the results into the destination: cleared positions there are also passed over. Taken together, the operation is a compress followed at once by an expand. When the destination mask is all ones, the block performs a plain compress. When the source mask is all ones, it performs a plain expand.

A start strobe captures the vector length, the two masks and two flags that mark each operand as a vector or a scalar. From then on the block offers at most one (source index, destination index) pair per cycle, and a ready input holds the current pair in place. The run ends with a one-cycle done pulse as soon as either index can no longer find a usable position below the vector length. The element operation and the register file access sit outside this block.

Top module: `twp_seq`

## Requirements
- R1: A start pulse while idle captures `vl_i`, both masks and both vector flags, and raises `busy_o` on the next cycle. A start pulse while `busy_o` is high is ignored and leaves the running sequence unchanged.
- R2: When the source is a vector (`src_vec_i`=1), the source index passes over every position whose bit in `src_mask_i` is 0. Bit k of a mask belongs to element k.
- R3: When the destination is a vector (`dst_vec_i`=1), the destination index passes over every position whose bit in `dst_mask_i` is 0.
- R4: When an operand is scalar (its vector flag is 0), its index takes the values 0, 1, 2, … one per accepted pair and ignores its mask.
- R5: After a pair is accepted (`pair_valid_o` and `ready_i` both high on a clock edge), each index searches again from one position above the value it just emitted.
- R6: When either index finds no usable position below the captured vector length, the block emits no pair, pulses `done_o` for exactly one cycle and returns to idle.
- R7: With a vector length of 0, `done_o` is high in the cycle after the start edge and no pair is emitted.
- R8: While `pair_valid_o` is high and `ready_i` is low, the offered pair stays valid and unchanged in the next cycle.
- R9: `pair_valid_o` and `done_o` are never high together, and both index outputs read 0 whenever `pair_valid_o` is low.
- R10: After reset the block is idle, with `busy_o`, `pair_valid_o` and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a sequence (accepted only while idle) |
| vl_i | input | 7 | Vector length, 0 to 64 |
| src_mask_i | input | 64 | Source predicate, bit k for element k |
| dst_mask_i | input | 64 | Destination predicate, bit k for element k |
| src_vec_i | input | 1 | Source is a vector (1) or a scalar (0) |
| dst_vec_i | input | 1 | Destination is a vector (1) or a scalar (0) |
| ready_i | input | 1 | Consumer accepts the offered pair |
| pair_valid_o | output | 1 | A pair is offered this cycle |
| src_idx_o | output | 6 | Source element index |
| dst_idx_o | output | 6 | Destination element index |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| busy_o | output | 1 | A sequence is in progress |

## Verification
Passing over masked positions and emitting a pair both happen in the same cycle. Each index jumps to its next set bit in the same cycle that the pair carrying it is offered, so a gap in a mask never costs an idle cycle. Sparse, gapped masks are applied to both sides together while `ready_i` toggles at random. A scoreboard model walks the two masks independently and queues the pairs it expects. Every accepted pair is compared with the head of that queue, and every held pair must match the pair offered in the cycle before.

// File: rtl/twp_pkg.sv
package twp_pkg;
   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/twp_first_set.sv
module twp_first_set #(
   parameter int WIDTH = 64,
   parameter int OUT_W = $clog2(WIDTH + 1)
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic [OUT_W-1:0] pos_o
);
   // Lowest set bit; WIDTH when none is set.
   always_comb begin
      pos_o = OUT_W'(WIDTH);
      for (int k = WIDTH - 1; k >= 0; k--) begin
         if (vec_i[k]) pos_o = OUT_W'(k);
      end
   end
endmodule

// File: rtl/twp_lane.sv
module twp_lane #(
   parameter int MAX_VL = 64,
   parameter int VL_W   = $clog2(MAX_VL + 1),
   parameter int IDX_W  = $clog2(MAX_VL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              is_vec_i,
   input  logic [MAX_VL-1:0] mask_i,
   input  logic              adv_i,
   output logic [VL_W-1:0]   pos_o
);
   logic [VL_W-1:0]   cnt_q;
   logic [MAX_VL-1:0] mask_q;
   logic              vec_q;
   logic [MAX_VL-1:0] hit;
   logic [VL_W-1:0]   found;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         mask_q <= '0;
         vec_q  <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= '0;
         mask_q <= mask_i;
         vec_q  <= is_vec_i;
      end else if (adv_i) begin
         cnt_q  <= pos_o + VL_W'(1);
      end
   end

   // Positions at or above the counter that are enabled.
   generate
      for (genvar b = 0; b < MAX_VL; b++) begin : g_hit
         assign hit[b] = mask_q[b] & (VL_W'(b) >= cnt_q);
      end
   endgenerate

   twp_first_set #(.WIDTH(MAX_VL), .OUT_W(VL_W)) u_find (
      .vec_i (hit),
      .pos_o (found)
   );

   assign pos_o = vec_q ? found : cnt_q;

   // R2 R3
   // An accepted vector position always carries an enabled mask bit.
   mask_honoured_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && vec_q) |-> mask_q[pos_o[IDX_W-1:0]]);

   // R5
   advance_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !load_i) |=> (cnt_q == $past(pos_o) + VL_W'(1)) || $past(pos_o) >= VL_W'(MAX_VL));
endmodule

// File: rtl/twp_seq.sv
module twp_seq #(
   parameter int MAX_VL = 64,
   parameter int VL_W   = $clog2(MAX_VL + 1),
   parameter int IDX_W  = $clog2(MAX_VL)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [VL_W-1:0]   vl_i,
   input  logic [MAX_VL-1:0] src_mask_i,
   input  logic [MAX_VL-1:0] dst_mask_i,
   input  logic              src_vec_i,
   input  logic              dst_vec_i,
   input  logic              ready_i,
   output logic              pair_valid_o,
   output logic [IDX_W-1:0]  src_idx_o,
   output logic [IDX_W-1:0]  dst_idx_o,
   output logic              done_o,
   output logic              busy_o
);
   import twp_pkg::*;

   generate
      if (MAX_VL < 2) begin : g_bad_len
         $error("twp_seq: MAX_VL must be at least 2");
      end
      if (VL_W < $clog2(MAX_VL + 1)) begin : g_bad_vlw
         $error("twp_seq: VL_W too narrow for MAX_VL");
      end
   endgenerate

   seq_state_e      state_q;
   logic [VL_W-1:0] vl_q;
   logic [VL_W-1:0] src_pos, dst_pos;
   logic            accept_start, go, adv;

   assign accept_start = start_i && (state_q == SEQ_IDLE);
   assign go           = (state_q == SEQ_RUN) && (src_pos < vl_q) && (dst_pos < vl_q);
   assign adv          = go && ready_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         vl_q    <= '0;
      end else if (accept_start) begin
         state_q <= SEQ_RUN;
         vl_q    <= vl_i;
      end else if (state_q == SEQ_RUN && !go) begin
         state_q <= SEQ_IDLE;
      end
   end

   twp_lane #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_src_lane (
      .clk (clk), .rst_n (rst_n), .load_i (accept_start), .is_vec_i (src_vec_i),
      .mask_i (src_mask_i), .adv_i (adv), .pos_o (src_pos)
   );

   twp_lane #(.MAX_VL(MAX_VL), .VL_W(VL_W), .IDX_W(IDX_W)) u_dst_lane (
      .clk (clk), .rst_n (rst_n), .load_i (accept_start), .is_vec_i (dst_vec_i),
      .mask_i (dst_mask_i), .adv_i (adv), .pos_o (dst_pos)
   );

   assign pair_valid_o = go;
   assign done_o       = (state_q == SEQ_RUN) && !go;
   assign busy_o       = (state_q == SEQ_RUN);
   assign src_idx_o    = go ? src_pos[IDX_W-1:0] : '0;
   assign dst_idx_o    = go ? dst_pos[IDX_W-1:0] : '0;

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o && !pair_valid_o && !busy_o);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid_o && !ready_i) |=> pair_valid_o && $stable(src_idx_o) && $stable(dst_idx_o));

   // R5
   idx_rising_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid_o && ready_i) |=> !pair_valid_o ||
         (src_idx_o > $past(src_idx_o) && dst_idx_o > $past(dst_idx_o)));

   // R1
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !done_o) |=> busy_o && vl_q == $past(vl_q));

   // R7
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_start && vl_i == '0) |=> done_o);
endmodule

// File: tb/twp_seq_bench.sv
module twp_seq_bench;
   localparam int MAX_VL = 64;
   localparam int VL_W   = 7;
   localparam int IDX_W  = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic [VL_W-1:0]   vl_i = '0;
   logic [MAX_VL-1:0] src_mask_i = '0, dst_mask_i = '0;
   logic              src_vec_i = 1'b0, dst_vec_i = 1'b0;
   logic              ready_i = 1'b1;
   logic              pair_valid_o, done_o, busy_o;
   logic [IDX_W-1:0]  src_idx_o, dst_idx_o;

   int checks = 0, failures = 0, dones_seen = 0, cycles = 0;
   bit rand_ready = 1'b0, finished = 1'b0;
   logic [2*IDX_W-1:0] exp_q[$];
   bit stall_pend = 1'b0;
   logic [IDX_W-1:0] held_s, held_d;

   always #4 clk = ~clk;

   twp_seq u_twp_seq (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .vl_i (vl_i),
      .src_mask_i (src_mask_i), .dst_mask_i (dst_mask_i),
      .src_vec_i (src_vec_i), .dst_vec_i (dst_vec_i), .ready_i (ready_i),
      .pair_valid_o (pair_valid_o), .src_idx_o (src_idx_o), .dst_idx_o (dst_idx_o),
      .done_o (done_o), .busy_o (busy_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Monitor: pops expected pairs as the design hands them over.
   always @(negedge clk) begin
      if (rst_n) begin
         if (pair_valid_o && done_o) check(1'b0, "R9 valid with done", 1, 0);
         if (!pair_valid_o && (src_idx_o != 0 || dst_idx_o != 0))
            check(1'b0, "R9 idle index", {src_idx_o, dst_idx_o}, 0);
         if (stall_pend)
            check(pair_valid_o && src_idx_o == held_s && dst_idx_o == held_d,
                  "R8 held pair", {pair_valid_o, src_idx_o, dst_idx_o}, {1'b1, held_s, held_d});
         stall_pend = pair_valid_o && !ready_i;
         held_s = src_idx_o;
         held_d = dst_idx_o;
         if (pair_valid_o && ready_i) begin
            if (exp_q.size() == 0) check(1'b0, "R6 extra pair", {src_idx_o, dst_idx_o}, -1);
            else begin
               logic [2*IDX_W-1:0] e;
               e = exp_q.pop_front();
               check({src_idx_o, dst_idx_o} == e, "R2/R3/R4/R5 pair",
                     {src_idx_o, dst_idx_o}, e);
            end
         end
         if (done_o) begin
            check(exp_q.size() == 0, "R6 pairs left at done", exp_q.size(), 0);
            dones_seen++;
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (rand_ready) ready_i = ($urandom % 3) != 0;
      else ready_i = 1'b1;
   end

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000 && !finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
         end
      end
   end

   // Reference walk of both masks.
   task automatic build_ref(input int vl, input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                            input bit sv, input bit dv);
      int i = 0, j = 0;
      forever begin
         if (sv) while (i < vl && !sm[i]) i++;
         if (dv) while (j < vl && !dm[j]) j++;
         if (i >= vl || j >= vl) break;
         exp_q.push_back({IDX_W'(i), IDX_W'(j)});
         i++;
         j++;
      end
   endtask

   task automatic run_op(input int vl, input logic [MAX_VL-1:0] sm, input logic [MAX_VL-1:0] dm,
                         input bit sv, input bit dv, input bit poke);
      int target;
      build_ref(vl, sm, dm, sv, dv);
      target = dones_seen + 1;
      @(posedge clk); #1;
      start_i = 1'b1; vl_i = VL_W'(vl);
      src_mask_i = sm; dst_mask_i = dm; src_vec_i = sv; dst_vec_i = dv;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      check(busy_o, "R1 busy after start", busy_o, 1);
      if (poke) begin
         // R1: a second start while busy must not disturb the sequence.
         @(posedge clk); #1;
         start_i = 1'b1; vl_i = 7'd3; src_mask_i = '1; dst_mask_i = '1;
         src_vec_i = 1'b0; dst_vec_i = 1'b0;
         @(posedge clk); #1;
         start_i = 1'b0;
      end
      while (dones_seen < target) @(negedge clk);
      @(negedge clk);
      check(!busy_o && !done_o, "R6 back to idle", {busy_o, done_o}, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R10
      check(!busy_o && !pair_valid_o && !done_o, "R10 reset idle",
            {busy_o, pair_valid_o, done_o}, 0);
      rst_n = 1'b1;

      // R2 R3: both vectors, gapped masks
      run_op(16, 64'h0000_0000_0000_A5C3, 64'h0000_0000_0000_3F18, 1, 1, 0);
      // pure compress: destination all ones
      run_op(64, 64'hF000_0F0F_0000_8001, '1, 1, 1, 0);
      // pure expand: source all ones
      run_op(20, '1, 64'h0000_0000_000A_AAAA, 1, 1, 0);
      // R4: scalar source ignores its mask
      run_op(10, 64'h0, 64'h0000_0000_0000_0355, 0, 1, 0);
      // R4: scalar destination
      run_op(8, 64'h0000_0000_0000_00E1, 64'h0, 1, 0, 0);
      // R6: empty source mask -> done, no pair
      run_op(12, 64'h0, '1, 1, 1, 0);
      // R6: set bits only at or above vl
      run_op(4, 64'h0000_0000_0000_00F0, '1, 1, 1, 0);

      // R7: zero length
      @(posedge clk); #1;
      start_i = 1'b1; vl_i = '0; src_mask_i = '1; dst_mask_i = '1;
      @(posedge clk); #1;
      start_i = 1'b0;
      @(negedge clk);
      check(done_o && !pair_valid_o, "R7 zero length done", {done_o, pair_valid_o}, 2);
      @(negedge clk);

      // R8 R5: random ready, sparse high masks, full length
      rand_ready = 1'b1;
      run_op(64, 64'h8421_0000_1248_0003, 64'hC000_00F0_0000_0101, 1, 1, 0);
      // R1: start while busy ignored
      run_op(32, '1, '1, 1, 1, 1);
      for (int n = 0; n < 12; n++)
         run_op(int'($urandom % 65), {$urandom, $urandom}, {$urandom, $urandom},
                bit'($urandom % 4 != 0), bit'($urandom % 4 != 0), 0);
      rand_ready = 1'b0;

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule